// File: doc/BRIEF.md
# Serial Receive/Transmit FIFO Pair with DMA Ready Signalling

This block sits between the bit shifters of a serial controller and its host side. It holds one receive queue and one transmit queue of bytes, 16 entries each by default. The shifter pushes received bytes and pops bytes to send. The host pops received bytes and pushes bytes to send. All of these ports are single-cycle strobes. A one-byte configuration write turns the queues on, empties either queue, picks the receive threshold and picks how the two DMA request lines behave.

The two active-low ready lines support two handshake styles. In the single-transfer style, a line follows the presence of data (receive) or the absence of data (transmit). In the burst style, a line asserts at a threshold and releases only at the opposite extreme, so that a DMA engine can move a block of bytes in one go. A character-timeout indication shows that received bytes are waiting below the threshold. With the queues turned off, each direction holds a single byte.

Top module: `sio_fifo_pair`

## Requirements
- R1: After reset both queues are empty, `rx_ready_n`=1, `tx_ready_n`=0, and `rx_trig`, `rx_timeout` and `rx_overrun` are all 0.
- R2: With configuration bit 0 set, each queue holds up to DEPTH bytes. `host_rx_data` and `shf_tx_data` always show the oldest held byte, and bytes leave in arrival order.
- R3: With configuration bit 0 clear, each queue holds one byte. A push to a queue that is already holding a byte is discarded.
- R4: A configuration write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue, on that write only; neither bit is stored. A write that changes bit 0 empties both queues.
- R5: Configuration bits 7:6 set the receive threshold: 00 is 1 byte, 01 is 4, 10 is 8 and 11 is 14. `rx_trig` is 1 when the queues are on and `rx_level` is at or above the threshold, one cycle after the level changes.
- R6: When configuration bit 3 is 0 or bit 0 is 0, `rx_ready_n` is 0 exactly when the receive queue holds a byte, one cycle behind `rx_level`.
- R7: When bits 0 and 3 are both 1, `rx_ready_n` goes to 0 once the threshold is reached or `rx_timeout` is 1. It stays 0 until the receive queue is empty.
- R8: In the single-transfer style, `tx_ready_n` is 0 exactly when the transmit queue is empty, one cycle behind `tx_level`.
- R9: In the burst style, `tx_ready_n` goes to 0 when the transmit queue is empty and returns to 1 only when the queue holds DEPTH bytes. Between those two points it keeps its value.
- R10: With the queues on and the receive queue holding bytes, `rx_timeout` rises after TIMEOUT_TICKS `bit_tick` pulses with no receive push or pop strobe. Such a strobe, a receive flush or an empty queue returns it to 0.
- R11: A receive push while the receive queue is at capacity discards the byte and sets `rx_overrun`. The flag stays set until a receive flush or reset.
- R12: A pop from an empty queue changes neither the queue level nor its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration byte (bit0 enable, bit1 rx flush, bit2 tx flush, bit3 burst style, bits7:6 threshold) |
| shf_rx_push | input | 1 | Receive shifter delivers a byte |
| shf_rx_data | input | DW | Byte from the receive shifter |
| host_rx_pop | input | 1 | Host takes the oldest received byte |
| host_rx_data | output | DW | Oldest received byte |
| host_tx_push | input | 1 | Host supplies a byte to send |
| host_tx_data | input | DW | Byte to send |
| shf_tx_pop | input | 1 | Transmit shifter takes the oldest byte |
| shf_tx_data | output | DW | Oldest byte waiting to send |
| bit_tick | input | 1 | One pulse per serial bit time |
| rx_level | output | LW | Bytes held in the receive queue |
| tx_level | output | LW | Bytes held in the transmit queue |
| rx_ready_n | output | 1 | Receive DMA request, active low |
| tx_ready_n | output | 1 | Transmit DMA request, active low |
| rx_trig | output | 1 | Receive threshold reached |
| rx_timeout | output | 1 | Receive character timeout |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The assertions check several properties on every cycle. Levels never exceed DEPTH. An empty receive queue always leads to a released receive line, and an empty transmit queue always leads to an asserted transmit line. A push into a full receive queue sets the overrun flag, and the flag holds until a configuration write. A timeout is never shown while the receive queue is empty. The style-dependent behaviour can only be shown by the bench's scenarios: the burst-style hold between threshold and empty, or between empty and full. The same goes for each threshold code, the byte order, the discarded byte itself, the self-clearing flush bits and the exact tick count of the timeout.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;

  typedef struct packed {
    logic [1:0] trig;
    logic       burst;
    logic       en;
  } fifo_cfg_t;

  // threshold in bytes for the two-bit receive threshold code
  function automatic int unsigned trig_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          at_cap, do_push, do_pop;

  always_comb begin
    at_cap  = single ? (level != '0) : (level == LW'(DEPTH));
    do_push = push && !at_cap && !flush;
    do_pop  = pop && (level != '0) && !flush;
    drop    = push && at_cap && !flush;
  end

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assign dout = mem[rd_ptr];

endmodule

// File: rtl/sio_rx_watch.sv
module sio_rx_watch #(
  parameter int LIMIT = 40,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic nonempty,
  input  logic activity,
  input  logic bit_tick,
  output logic timeout
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en || !nonempty || activity) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (bit_tick) begin
      if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
      if (cnt == CW'(LIMIT - 1)) timeout <= 1'b1;
    end
  end

endmodule

// File: rtl/sio_dma_ready.sv
module sio_dma_ready
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  fifo_cfg_t     cfg,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          rx_timeout,
  output logic          rx_ready_n,
  output logic          tx_ready_n,
  output logic          rx_trig
);
  logic burst_on, trig_hit, rx_n_nxt, tx_n_nxt;

  always_comb begin
    burst_on = cfg.en && cfg.burst;
    trig_hit = cfg.en && (int'(rx_level) >= int'(trig_bytes(cfg.trig)));

    rx_n_nxt = rx_ready_n;
    if (rx_level == '0)            rx_n_nxt = 1'b1;
    else if (!burst_on)            rx_n_nxt = 1'b0;
    else if (trig_hit || rx_timeout) rx_n_nxt = 1'b0;

    tx_n_nxt = tx_ready_n;
    if (tx_level == '0)                 tx_n_nxt = 1'b0;
    else if (!burst_on)                 tx_n_nxt = 1'b1;
    else if (tx_level == LW'(DEPTH))    tx_n_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ready_n <= 1'b1;
      tx_ready_n <= 1'b0;
      rx_trig    <= 1'b0;
    end else begin
      rx_ready_n <= rx_n_nxt;
      tx_ready_n <= tx_n_nxt;
      rx_trig    <= trig_hit;
    end
  end

endmodule

// File: rtl/sio_fifo_pair.sv
module sio_fifo_pair
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int DW            = 8,
  parameter int TIMEOUT_TICKS = 40,
  localparam int LW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_data,
  input  logic          shf_rx_push,
  input  logic [DW-1:0] shf_rx_data,
  input  logic          host_rx_pop,
  output logic [DW-1:0] host_rx_data,
  input  logic          host_tx_push,
  input  logic [DW-1:0] host_tx_data,
  input  logic          shf_tx_pop,
  output logic [DW-1:0] shf_tx_data,
  input  logic          bit_tick,
  output logic [LW-1:0] rx_level,
  output logic [LW-1:0] tx_level,
  output logic          rx_ready_n,
  output logic          tx_ready_n,
  output logic          rx_trig,
  output logic          rx_timeout,
  output logic          rx_overrun
);
  fifo_cfg_t cfg;
  logic      en_change, rx_flush, tx_flush, rx_drop, tx_drop;

  always_comb begin
    en_change = cfg_wr && (cfg_data[0] != cfg.en);
    rx_flush  = en_change || (cfg_wr && cfg_data[1]);
    tx_flush  = en_change || (cfg_wr && cfg_data[2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (cfg_wr) begin
      cfg.en    <= cfg_data[0];
      cfg.burst <= cfg_data[3];
      cfg.trig  <= cfg_data[7:6];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rx_flush) rx_overrun <= 1'b0;
    else if (rx_drop)    rx_overrun <= 1'b1;
  end

  sio_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .single(!cfg.en),
    .push(shf_rx_push), .din(shf_rx_data), .pop(host_rx_pop),
    .dout(host_rx_data), .level(rx_level), .drop(rx_drop)
  );

  sio_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .single(!cfg.en),
    .push(host_tx_push), .din(host_tx_data), .pop(shf_tx_pop),
    .dout(shf_tx_data), .level(tx_level), .drop(tx_drop)
  );

  sio_rx_watch #(.LIMIT(TIMEOUT_TICKS)) u_watch (
    .clk(clk), .rst(rst), .en(cfg.en), .nonempty(rx_level != '0),
    .activity(shf_rx_push || host_rx_pop || rx_flush),
    .bit_tick(bit_tick), .timeout(rx_timeout)
  );

  sio_dma_ready #(.DEPTH(DEPTH)) u_ready (
    .clk(clk), .rst(rst), .cfg(cfg), .rx_level(rx_level),
    .tx_level(tx_level), .rx_timeout(rx_timeout),
    .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n), .rx_trig(rx_trig)
  );

  // a transmit push into a full queue is silently dropped
  logic unused_tx_drop;
  assign unused_tx_drop = tx_drop;

endmodule

// File: rtl/sio_fifo_pair_chk.sv
module sio_fifo_pair_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr,
  input logic          shf_rx_push,
  input logic          host_rx_pop,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          rx_ready_n,
  input logic          tx_ready_n,
  input logic          rx_overrun,
  input logic          rx_timeout
);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));

  assert_rx_release_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> rx_ready_n);

  assert_tx_request_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_level == '0) |=> !tx_ready_n);

  assert_overrun_set_R11: assert property (@(posedge clk) disable iff (rst)
    (shf_rx_push && !host_rx_pop && !cfg_wr && rx_level == LW'(DEPTH))
      |=> rx_overrun);

  assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !cfg_wr) |=> rx_overrun);

  assert_timeout_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
    rx_timeout |-> (rx_level != '0));

endmodule

bind sio_fifo_pair sio_fifo_pair_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .shf_rx_push(shf_rx_push),
  .host_rx_pop(host_rx_pop), .rx_level(rx_level), .tx_level(tx_level),
  .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n),
  .rx_overrun(rx_overrun), .rx_timeout(rx_timeout)
);

// File: tb/sio_fifo_pair_tb.sv
module sio_fifo_pair_tb;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int TMO   = 40;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic shf_rx_push = 1'b0;
  logic [DW-1:0] shf_rx_data = '0;
  logic host_rx_pop = 1'b0;
  logic [DW-1:0] host_rx_data;
  logic host_tx_push = 1'b0;
  logic [DW-1:0] host_tx_data = '0;
  logic shf_tx_pop = 1'b0;
  logic [DW-1:0] shf_tx_data;
  logic bit_tick = 1'b0;
  logic [LW-1:0] rx_level, tx_level;
  logic rx_ready_n, tx_ready_n, rx_trig, rx_timeout, rx_overrun;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sio_fifo_pair #(.DEPTH(DEPTH), .DW(DW), .TIMEOUT_TICKS(TMO)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .shf_rx_push(shf_rx_push), .shf_rx_data(shf_rx_data),
    .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
    .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
    .shf_tx_pop(shf_tx_pop), .shf_tx_data(shf_tx_data),
    .bit_tick(bit_tick), .rx_level(rx_level), .tx_level(tx_level),
    .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n), .rx_trig(rx_trig),
    .rx_timeout(rx_timeout), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] v);
    cfg_data = v; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    idle(2);
  endtask

  task automatic rx_in(input logic [7:0] b);
    shf_rx_data = b; shf_rx_push = 1'b1;
    @(negedge clk);
    shf_rx_push = 1'b0;
  endtask

  task automatic rx_out(output logic [7:0] b);
    b = host_rx_data; host_rx_pop = 1'b1;
    @(negedge clk);
    host_rx_pop = 1'b0;
  endtask

  task automatic tx_in(input logic [7:0] b);
    host_tx_data = b; host_tx_push = 1'b1;
    @(negedge clk);
    host_tx_push = 1'b0;
  endtask

  task automatic tx_out(output logic [7:0] b);
    b = shf_tx_data; shf_tx_pop = 1'b1;
    @(negedge clk);
    shf_tx_pop = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; @(negedge clk);
      bit_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 tx_level", int'(tx_level), 0);
    chk("R1 rx_ready_n", int'(rx_ready_n), 1);
    chk("R1 tx_ready_n", int'(tx_ready_n), 0);
    chk("R1 flags", int'({rx_trig, rx_timeout, rx_overrun}), 0);
  endtask

  task automatic t_disabled();
    logic [7:0] b;
    cfg(8'h08);                     // queues off, burst bit set but ignored
    rx_in(8'hA5); rx_in(8'h5A); idle(2);
    chk("R3 rx single level", int'(rx_level), 1);
    chk("R3 rx kept first", int'(host_rx_data), 8'hA5);
    chk("R11 overrun in single mode", int'(rx_overrun), 1);
    chk("R6 ready with queues off", int'(rx_ready_n), 0);
    chk("R5 no trig when off", int'(rx_trig), 0);
    tx_in(8'h11); tx_in(8'h22); idle(2);
    chk("R3 tx single level", int'(tx_level), 1);
    chk("R3 tx kept first", int'(shf_tx_data), 8'h11);
    chk("R8 tx busy", int'(tx_ready_n), 1);
    tx_out(b); idle(2);
    chk("R8 tx empty again", int'(tx_ready_n), 0);
    rx_out(b); idle(2);
    chk("R6 rx released", int'(rx_ready_n), 1);
  endtask

  task automatic t_order();
    logic [7:0] b;
    cfg(8'h01);
    chk("R11 cleared by enable change", int'(rx_overrun), 0);
    for (int i = 0; i < DEPTH; i++) rx_in(8'(8'h30 + i));
    idle(2);
    chk("R2 rx full level", int'(rx_level), DEPTH);
    chk("R6 mode0 ready", int'(rx_ready_n), 0);
    chk("R11 no overrun at exact fill", int'(rx_overrun), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rx_out(b);
      chk("R2 rx order", int'(b), 8'h30 + i);
    end
    tx_in(8'hC1); tx_in(8'hC2); tx_in(8'hC3);
    for (int i = 0; i < 3; i++) begin
      tx_out(b);
      chk("R2 tx order", int'(b), 8'hC1 + i);
    end
    idle(2);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 3; i++) begin rx_in(8'(i)); tx_in(8'(i)); end
    cfg(8'h03);
    chk("R4 rx flushed", int'(rx_level), 0);
    chk("R4 tx untouched", int'(tx_level), 3);
    cfg(8'h01);
    chk("R4 flush bit not stored", int'(tx_level), 3);
    cfg(8'h05);
    chk("R4 tx flushed", int'(tx_level), 0);
  endtask

  task automatic t_trig();
    int th;
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: th = 1; 1: th = 4; 2: th = 8; default: th = 14;
      endcase
      cfg(8'((c << 6) | 3));
      for (int i = 0; i < th - 1; i++) rx_in(8'(i));
      idle(2);
      chk("R5 below threshold", int'(rx_trig), 0);
      rx_in(8'hEE); idle(2);
      chk("R5 at threshold", int'(rx_trig), 1);
    end
    cfg(8'h03);
  endtask

  task automatic t_rx_burst();
    logic [7:0] b;
    cfg(8'h8B);                     // threshold 8, burst, rx flush
    for (int i = 0; i < 7; i++) rx_in(8'(i));
    idle(2);
    chk("R7 held back below threshold", int'(rx_ready_n), 1);
    rx_in(8'h07); idle(2);
    chk("R7 asserted at threshold", int'(rx_ready_n), 0);
    for (int i = 0; i < 7; i++) rx_out(b);
    idle(2);
    chk("R7 held while not empty", int'(rx_ready_n), 0);
    rx_out(b); idle(2);
    chk("R7 released when empty", int'(rx_ready_n), 1);
  endtask

  task automatic t_tx_burst();
    logic [7:0] b;
    cfg(8'h0D);                     // burst, tx flush
    chk("R9 empty requests", int'(tx_ready_n), 0);
    for (int i = 0; i < DEPTH - 1; i++) tx_in(8'(i));
    idle(2);
    chk("R9 held until full", int'(tx_ready_n), 0);
    tx_in(8'hFF); idle(2);
    chk("R9 released when full", int'(tx_ready_n), 1);
    tx_out(b); idle(2);
    chk("R9 stays released", int'(tx_ready_n), 1);
    for (int i = 0; i < DEPTH - 1; i++) tx_out(b);
    idle(2);
    chk("R9 requests when empty", int'(tx_ready_n), 0);
  endtask

  task automatic t_timeout();
    logic [7:0] b;
    cfg(8'hCB);                     // threshold 14, burst, rx flush
    rx_in(8'h61); rx_in(8'h62); idle(2);
    chk("R7 no request yet", int'(rx_ready_n), 1);
    ticks(TMO - 1);
    chk("R10 not yet timed out", int'(rx_timeout), 0);
    ticks(1);
    chk("R10 timed out", int'(rx_timeout), 1);
    idle(1);
    chk("R7 request from timeout", int'(rx_ready_n), 0);
    rx_out(b); idle(2);
    chk("R10 cleared by pop", int'(rx_timeout), 0);
    chk("R7 held with byte left", int'(rx_ready_n), 0);
    cfg(8'h03);
  endtask

  task automatic t_overrun();
    logic [7:0] b;
    for (int i = 0; i <= DEPTH; i++) rx_in(8'(8'h40 + i));
    idle(2);
    chk("R11 level capped", int'(rx_level), DEPTH);
    chk("R11 overrun set", int'(rx_overrun), 1);
    for (int i = 0; i < DEPTH; i++) begin
      rx_out(b);
      chk("R11 extra byte dropped", int'(b), 8'h40 + i);
    end
    idle(2);
    chk("R11 sticky after drain", int'(rx_overrun), 1);
    cfg(8'h03);
    chk("R11 cleared by flush", int'(rx_overrun), 0);
  endtask

  task automatic t_pop_empty();
    logic [7:0] b;
    cfg(8'h07);
    rx_out(b); tx_out(b); idle(2);
    chk("R12 rx level after empty pop", int'(rx_level), 0);
    chk("R12 tx level after empty pop", int'(tx_level), 0);
    rx_in(8'h33); idle(2);
    chk("R12 rx data intact", int'(host_rx_data), 8'h33);
    chk("R12 rx level one", int'(rx_level), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_order();
    t_clear();
    t_trig();
    t_rx_burst();
    t_tx_burst();
    t_timeout();
    t_overrun();
    t_pop_empty();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule